// File: doc/BRIEF.md
# Command-Addressed Serial Peripheral Port

This block is the device end of a four-wire serial bus with an active-low select line, a serial clock, a command-data input line and a reply-data output line. Each transaction begins with one address/command byte. The command code sets what follows: nothing, one or two bytes written toward the device, or a two-byte reply shifted back to the bus master. The port runs on a fast system clock and oversamples all three bus inputs through synchronizers. It works with either resting level of the serial clock.

When a command is complete, the port raises a one-cycle strobe toward a register file. The strobe carries the command code and the assembled data word. For reads, the register file provides the reply word on a parallel input. The port captures that word when the command byte ends and shifts it out. A transaction that the master ends early leaves no trace. The reply line is released to high impedance, signalled by an output-enable pin for the pad, whenever no read is in its data phase.

Top module: `cps_port`

## Requirements
- R1: The two most significant bits of the command byte select its kind: 00 no data bytes, 01 one write byte, 10 two write bytes, 11 two-byte read. The full code is delivered on `cmd_code`.
- R2: Bits travel most significant first on both data lines. A one-byte write is delivered in `cmd_data[7:0]` with `cmd_data[15:8]` zero. For a two-byte write, the first byte received lands in `cmd_data[15:8]`.
- R3: The clock level sampled when select is asserted is taken as the resting level. Input bits are sampled on the clock edge that leaves that level, for both resting levels.
- R4: `cmd_valid` is high for exactly one system clock, while select is still asserted, once the last required bit has arrived. `cmd_code` and `cmd_data` hold their values until the next strobe.
- R5: If select is released before the required bit count is reached, no strobe is issued and `cmd_code`/`cmd_data` are unchanged.
- R6: Bits clocked in after a command is complete are ignored, and only one strobe is issued per transaction.
- R7: For a read, `reply_data` is captured when the command byte completes. Its most significant bit is driven first, and the next bit appears after each active clock edge. `cmd_data` is zero for read and no-data commands.
- R8: `bus_miso_oe` is high only during the data phase of a read. It is low during the command byte and during writes, and it drops within SYNC_STAGES+2 system clocks after select is released.
- R9: During and right after reset, `cmd_valid`, `bus_miso_oe`, `cmd_code` and `cmd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_csn | input | 1 | Active-low transaction select |
| bus_sck | input | 1 | Serial clock, either resting level |
| bus_mosi | input | 1 | Command and write data from the master |
| bus_miso | output | 1 | Reply data toward the master |
| bus_miso_oe | output | 1 | Pad enable for bus_miso; low means high impedance |
| reply_data | input | 2*BYTE_W | Reply word from the register file |
| cmd_valid | output | 1 | One-cycle completed-command strobe |
| cmd_code | output | BYTE_W | Code of the last completed command |
| cmd_data | output | 2*BYTE_W | Data word of the last completed command |

## Verification
Every cycle, the checker confirms four things. The strobe never lasts beyond one cycle. The delivered code and data move only together with a strobe. A strobe follows only a cycle in which the synchronized select was low. The reply enable is high only for a read kind and falls within the bounded time after select goes high. The bench scenarios are needed to show the content-level behaviour: correct bit order and byte placement for every command kind, sampling on the proper edge for both clock resting levels, the reply bit sequence, the discarding of early-ended transactions, and the ignoring of surplus bits.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
package cps_pkg;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_WR1  = 2'd1,
    K_WR2  = 2'd2,
    K_RD2  = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_CMD  = 2'd1,
    S_DATA = 2'd2,
    S_DONE = 2'd3
  } frame_st_e;

  // Kind selected by the two top bits of the command byte.
  function automatic cmd_kind_e kind_of(input logic [1:0] sel);
    return cmd_kind_e'(sel);
  endfunction

  // Number of data bytes that follow the command byte.
  function automatic logic [1:0] bytes_of(input cmd_kind_e k);
    case (k)
      K_NONE:  return 2'd0;
      K_WR1:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/cps_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a group of asynchronous inputs.
// STAGES must be 2 or more.
module cps_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] chain_nxt;

  always_comb begin
    chain_nxt = {chain[CHAIN_W-W-1:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= chain_nxt;
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/cps_edge.sv
`timescale 1ns/1ps
// Select framing and active-edge detection with polarity capture.
module cps_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic csn_s,
  input  logic sck_s,
  output logic cs_start,
  output logic cs_end,
  output logic act_edge
);
  logic csn_d, sck_d, idle_lvl;
  logic idle_nxt;
  logic idle_en;

  assign cs_start = csn_d & ~csn_s;
  assign cs_end   = ~csn_d & csn_s;
  assign idle_en  = cs_start;

  always_comb begin
    idle_nxt = idle_lvl;
    if (idle_en) idle_nxt = sck_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_d    <= 1'b1;
      sck_d    <= 1'b0;
      idle_lvl <= 1'b0;
    end else begin
      csn_d    <= csn_s;
      sck_d    <= sck_s;
      idle_lvl <= idle_nxt;
    end
  end

  // Edge leaving the resting level, only inside a held select window.
  assign act_edge = ~csn_s & ~csn_d & (sck_s ^ sck_d) & (sck_s ^ idle_lvl);
endmodule

// File: rtl/cps_frame.sv
`timescale 1ns/1ps
// Transaction sequencer: command decode, data assembly, reply shifting.
module cps_frame
  import cps_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_start,
  input  logic                cs_end,
  input  logic                act_edge,
  input  logic                mosi_s,
  input  logic [2*BYTE_W-1:0] reply_data,
  output logic                strobe,
  output logic [BYTE_W-1:0]   code_q,
  output logic [2*BYTE_W-1:0] data_q,
  output logic                rep_msb,
  output logic                rd_phase,
  output cmd_kind_e           kind_q
);
  localparam int DATA_W = 2 * BYTE_W;
  localparam int BW     = $clog2(BYTE_W);

  frame_st_e          st, st_n;
  logic [BW-1:0]      bit_cnt, bit_n;
  logic [1:0]         byte_cnt, byte_n;
  logic [BYTE_W-1:0]  code_sh, code_sh_n, code_full, code_q_n;
  logic [DATA_W-1:0]  data_sh, data_sh_n, data_q_n;
  logic [DATA_W-1:0]  rep_sh, rep_n;
  cmd_kind_e          kind_n, new_kind;
  logic               rd_n, strobe_n, last_bit;

  assign last_bit  = (bit_cnt == BW'(BYTE_W - 1));
  assign code_full = {code_sh[BYTE_W-2:0], mosi_s};
  assign new_kind  = kind_of(code_full[BYTE_W-1 -: 2]);

  always_comb begin
    st_n      = st;
    bit_n     = bit_cnt;
    byte_n    = byte_cnt;
    code_sh_n = code_sh;
    data_sh_n = data_sh;
    rep_n     = rep_sh;
    kind_n    = kind_q;
    rd_n      = rd_phase;
    strobe_n  = 1'b0;
    code_q_n  = code_q;
    data_q_n  = data_q;
    if (cs_end) begin
      st_n = S_IDLE;
      rd_n = 1'b0;
    end else if (cs_start) begin
      st_n      = S_CMD;
      bit_n     = '0;
      byte_n    = '0;
      code_sh_n = '0;
      data_sh_n = '0;
      rd_n      = 1'b0;
    end else if (act_edge) begin
      case (st)
        S_CMD: begin
          code_sh_n = code_full;
          bit_n     = bit_cnt + BW'(1);
          if (last_bit) begin
            bit_n  = '0;
            kind_n = new_kind;
            rd_n   = (new_kind == K_RD2);
            if (new_kind == K_RD2) rep_n = reply_data;
            if (bytes_of(new_kind) == 2'd0) begin
              st_n     = S_DONE;
              strobe_n = 1'b1;
              code_q_n = code_full;
              data_q_n = '0;
            end else begin
              st_n   = S_DATA;
              byte_n = '0;
            end
          end
        end
        S_DATA: begin
          data_sh_n = {data_sh[DATA_W-2:0], mosi_s};
          rep_n     = {rep_sh[DATA_W-2:0], 1'b0};
          bit_n     = bit_cnt + BW'(1);
          if (last_bit) begin
            bit_n  = '0;
            byte_n = byte_cnt + 2'd1;
            if ((byte_cnt + 2'd1) == bytes_of(kind_q)) begin
              st_n     = S_DONE;
              strobe_n = 1'b1;
              code_q_n = code_sh;
              data_q_n = (kind_q == K_RD2) ? '0 : data_sh_n;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      bit_cnt  <= '0;
      byte_cnt <= '0;
      code_sh  <= '0;
      data_sh  <= '0;
      rep_sh   <= '0;
      kind_q   <= K_NONE;
      rd_phase <= 1'b0;
      strobe   <= 1'b0;
      code_q   <= '0;
      data_q   <= '0;
    end else begin
      st       <= st_n;
      bit_cnt  <= bit_n;
      byte_cnt <= byte_n;
      code_sh  <= code_sh_n;
      data_sh  <= data_sh_n;
      rep_sh   <= rep_n;
      kind_q   <= kind_n;
      rd_phase <= rd_n;
      strobe   <= strobe_n;
      code_q   <= code_q_n;
      data_q   <= data_q_n;
    end
  end

  assign rep_msb = rep_sh[DATA_W-1];
endmodule

// File: rtl/cps_port.sv
`timescale 1ns/1ps
module cps_port
  import cps_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_csn,
  input  logic                bus_sck,
  input  logic                bus_mosi,
  output logic                bus_miso,
  output logic                bus_miso_oe,
  input  logic [2*BYTE_W-1:0] reply_data,
  output logic                cmd_valid,
  output logic [BYTE_W-1:0]   cmd_code,
  output logic [2*BYTE_W-1:0] cmd_data
);
  logic [2:0] raw_in, sync_out;
  logic       csn_s, sck_s, mosi_s;
  logic       cs_start, cs_end, act_edge;
  logic       rep_msb, rd_phase;
  cmd_kind_e  frame_kind;

  assign raw_in = {bus_csn, bus_sck, bus_mosi};

  cps_sync #(
    .W      (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (sync_out)
  );

  assign csn_s  = sync_out[2];
  assign sck_s  = sync_out[1];
  assign mosi_s = sync_out[0];

  cps_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .csn_s   (csn_s),
    .sck_s   (sck_s),
    .cs_start(cs_start),
    .cs_end  (cs_end),
    .act_edge(act_edge)
  );

  cps_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_start  (cs_start),
    .cs_end    (cs_end),
    .act_edge  (act_edge),
    .mosi_s    (mosi_s),
    .reply_data(reply_data),
    .strobe    (cmd_valid),
    .code_q    (cmd_code),
    .data_q    (cmd_data),
    .rep_msb   (rep_msb),
    .rd_phase  (rd_phase),
    .kind_q    (frame_kind)
  );

  assign bus_miso_oe = rd_phase;
  assign bus_miso    = rd_phase & rep_msb;
endmodule

// File: rtl/cps_port_chk.sv
`timescale 1ns/1ps
module cps_port_chk
  import cps_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_csn,
  input logic                bus_miso_oe,
  input logic                cmd_valid,
  input logic [BYTE_W-1:0]   cmd_code,
  input logic [2*BYTE_W-1:0] cmd_data,
  input logic                csn_s,
  input cmd_kind_e           kind_q
);
  localparam int LIM_I = SYNC_STAGES + 1;
  localparam int CW    = $clog2(LIM_I + 1);
  localparam logic [CW-1:0] LIM = CW'(LIM_I);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hi_cnt <= '0;
    else if (!bus_csn)       hi_cnt <= '0;
    else if (hi_cnt != LIM)  hi_cnt <= hi_cnt + CW'(1);
  end

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  p_hold_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> ($stable(cmd_code) && $stable(cmd_data)));

  p_strobe_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(!csn_s));

  p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_miso_oe |-> (kind_q == K_RD2));

  p_oe_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_csn && hi_cnt == LIM) |-> !bus_miso_oe);
endmodule

bind cps_port cps_port_chk #(
  .BYTE_W     (BYTE_W),
  .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_csn    (bus_csn),
  .bus_miso_oe(bus_miso_oe),
  .cmd_valid  (cmd_valid),
  .cmd_code   (cmd_code),
  .cmd_data   (cmd_data),
  .csn_s      (csn_s),
  .kind_q     (frame_kind)
);

// File: tb/cps_port_tb.sv
`timescale 1ns/1ps
module cps_port_tb;
  localparam int HALF = 6;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_csn = 1'b1;
  logic        bus_sck = 1'b0;
  logic        bus_mosi = 1'b0;
  logic [15:0] reply_data = '0;
  logic        bus_miso, bus_miso_oe, cmd_valid;
  logic [7:0]  cmd_code;
  logic [15:0] cmd_data;

  int n_chk = 0;
  int n_fail = 0;
  int strobe_total = 0;
  logic [7:0]  cap_code = '0;
  logic [15:0] cap_data = '0;
  logic        cap_csn = 1'b1;
  logic [7:0]  last_code = '0;
  logic [15:0] last_data = '0;

  always #4 clk = ~clk;

  cps_port #(.BYTE_W(8), .SYNC_STAGES(SYNC)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_csn    (bus_csn),
    .bus_sck    (bus_sck),
    .bus_mosi   (bus_mosi),
    .bus_miso   (bus_miso),
    .bus_miso_oe(bus_miso_oe),
    .reply_data (reply_data),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .cmd_data   (cmd_data)
  );

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      strobe_total = strobe_total + 1;
      cap_code = cmd_code;
      cap_data = cmd_data;
      cap_csn  = bus_csn;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int need_of(input logic [1:0] kd);
    return (kd == 2'd0) ? 8 : (kd == 2'd1) ? 16 : 24;
  endfunction

  task automatic xact(input logic pol, input logic [7:0] code, input logic [15:0] wd,
                      input int nbits, input logic [15:0] rdat);
    logic [23:0] frm;
    logic [1:0]  kd;
    logic [15:0] exp_d;
    int need, s0;
    frm  = {code, wd};
    kd   = code[7:6];
    need = need_of(kd);
    reply_data = rdat;
    s0 = strobe_total;
    bus_sck = pol;
    repeat (4) @(negedge clk);
    bus_csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      bus_mosi = (i < 24) ? frm[23-i] : 1'b0;
      repeat (HALF) @(negedge clk);
      if (i == 4)
        chk(bus_miso_oe === 1'b0, "R8 oe low in command byte", 32'(bus_miso_oe), 32'd0);
      if (i >= 8 && i < need) begin
        if (kd == 2'd3) begin
          chk(bus_miso_oe === 1'b1, "R8 oe high in read data", 32'(bus_miso_oe), 32'd1);
          chk(bus_miso === rdat[15-(i-8)], "R7 reply bit order", 32'(bus_miso), 32'(rdat[15-(i-8)]));
        end else begin
          chk(bus_miso_oe === 1'b0, "R8 oe low in write data", 32'(bus_miso_oe), 32'd0);
        end
      end
      bus_sck = ~pol;
      repeat (HALF) @(negedge clk);
      bus_sck = pol;
    end
    repeat (HALF) @(negedge clk);
    bus_csn = 1'b1;
    repeat (SYNC + 3) @(negedge clk);
    chk(bus_miso_oe === 1'b0, "R8 oe released after select", 32'(bus_miso_oe), 32'd0);
    repeat (4) @(negedge clk);
    if (nbits >= need) begin
      exp_d = (kd == 2'd1) ? {8'h00, wd[15:8]} : (kd == 2'd2) ? wd : 16'h0000;
      chk(strobe_total - s0 == 1, "R4 R6 single strobe", 32'(strobe_total - s0), 32'd1);
      chk(cap_code === code, "R1 command code", 32'(cap_code), 32'(code));
      chk(cap_data === exp_d, "R2 R3 R7 data word", 32'(cap_data), 32'(exp_d));
      chk(cap_csn === 1'b0, "R4 strobe before select release", 32'(cap_csn), 32'd0);
      last_code = code;
      last_data = exp_d;
    end else begin
      chk(strobe_total == s0, "R5 no strobe on early end", 32'(strobe_total - s0), 32'd0);
      chk(cmd_code === last_code && cmd_data === last_data, "R5 outputs held",
          {8'h00, cmd_code, cmd_data}, {8'h00, last_code, last_data});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid === 1'b0 && bus_miso_oe === 1'b0, "R9 outputs low in reset",
        {30'd0, cmd_valid, bus_miso_oe}, 32'd0);
    chk(cmd_code === 8'h00 && cmd_data === 16'h0000, "R9 code and data zero in reset",
        {8'h00, cmd_code, cmd_data}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cmd_valid === 1'b0 && bus_miso_oe === 1'b0, "R9 outputs low after reset",
        {30'd0, cmd_valid, bus_miso_oe}, 32'd0);

    // Sweep: both clock resting levels (R3), all kinds, varied data, some surplus bits (R6).
    for (int p = 0; p < 2; p++) begin
      for (int j = 0; j < 64; j++) begin
        logic [7:0]  code;
        logic [15:0] wd, rd;
        int nb;
        code = {j[5:0], j[1:0] ^ {p[0], ~p[0]}};
        wd   = 16'hA5C3 ^ 16'(j * 16'h0F1D) ^ {16{p[0]}};
        rd   = {wd[6:0], wd[15:7]} ^ 16'h3C96;
        nb   = need_of(code[7:6]) + ((j % 5 == 0) ? 8 : 0);
        xact(p[0], code, wd, nb, rd);
      end
    end

    // Early select release for each kind and both resting levels (R5).
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] code;
        code = {k[1:0], 6'h15 ^ 6'(k)};
        xact(p[0], code, 16'h5A3C, need_of(k[1:0]) - 1, 16'hFFFF);
        xact(p[0], code, 16'hC33C, 3, 16'h8001);
      end
    end
    xact(1'b0, 8'h40, 16'h1234, 0, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule